// File: doc/BRIEF.md
# Serial Flash Write-Protect Gate

This block judges, one command at a time, whether a command that would change a serial NAND-style flash device may go ahead. A command decoder upstream hands it the command's class and target block. The gate combines these with four other inputs: the active-low protect pin, a protection-mode bit, a 4-bit block-protect code and a 2-bit status-protect field. It answers with a one-cycle allow or reject pulse. It also raises a strobe to the array only for accepted program and erase commands.

The protect pin is sampled when chip select falls. Whatever it does later in the same command has no effect. In software mode the pin guards only the first status register, and it may be taken over as a quad data line. The gate reports that takeover on its own flag. In hardware mode the pin low makes the whole device read-only, and quad reads are refused at any pin level.

The block-protect code selects a region at the top of the array. The region is two blocks at code 1 and doubles with each code step until it covers the whole array.

Top module: `flash_wp_gate`

## Requirements
- R1: While `rst_n` is low and after reset, `cmd_allow`, `cmd_reject`, `array_go`, `grant` and `wp_io` are all 0.
- R2: `wp_n` is sampled on the clock edge where `cs_n` is first seen low. Later changes of `wp_n` before `cs_n` rises have no effect on that command's decision.
- R3: A command is accepted when `cmd_valid` is 1 and `cs_n` is 0. Exactly one of `cmd_allow` or `cmd_reject` is then 1 for exactly one cycle, the cycle after acceptance. Class codes are: 0 read, 1 status-register-1 write, 2 other register write, 3 program, 4 erase, 5 OTP write, 6 quad read, 7 reserved.
- R4: With `hw_mode`=1 and the sampled pin low, classes 1, 2, 3, 4 and 5 are rejected.
- R5: With `hw_mode`=1, class 6 is rejected whatever the pin level.
- R6: With `hw_mode`=0, class 1 is rejected only if the sampled pin is low and `srp`=2'b01. With `hw_mode`=0, classes 2 and 5 are allowed at any pin level.
- R7: Classes 3 and 4 are rejected when the block lies in the protected range. With N=2^BLK_AW blocks, code 0 protects nothing. A code c from 1 to BLK_AW-1 protects blocks N-2^c to N-1. A code c ≥ BLK_AW protects every block.
- R8: `array_go` pulses together with `cmd_allow`, and only for an allowed class 3 or 4.
- R9: `grant` is 1 after an allowed command and holds until `cs_n` is seen high. After a rejected command `grant` stays 0.
- R10: `wp_io` becomes 1 after an allowed class 6 command (software mode only). It returns to 0 on the first edge where `cs_n` is high.
- R11: Classes 0 and 7 are always allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_class | input | 3 | Command class code |
| blk_addr | input | BLK_AW | Target block index |
| wp_n | input | 1 | Protect pin, active low |
| hw_mode | input | 1 | 1 = hardware protection mode |
| bp | input | 4 | Block-protect range code |
| srp | input | 2 | Status-protect field |
| cmd_allow | output | 1 | One-cycle accept pulse |
| cmd_reject | output | 1 | One-cycle reject pulse |
| array_go | output | 1 | One-cycle array write/erase strobe |
| grant | output | 1 | Decision held for the open command |
| wp_io | output | 1 | Protect pin owned by quad I/O |

## Verification
The policy is swept over every combination of class, mode, pin level and status-protect value. This separates the hardware read-only case from the status-only case, and shows that the quad-read refusal does not depend on the pin. The range decoder is swept over all 16 codes and every block of a 64-block array. This finds off-by-one errors at the region edge and the saturation to the whole array. In every command the pin is flipped after chip select falls. An early or late sample would therefore change the result. Each command then checks the pulse width, the held grant and the release of the quad flag when chip select rises.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  typedef enum logic [2:0] {
    CL_READ    = 3'd0,
    CL_SR1_WR  = 3'd1,
    CL_REG_WR  = 3'd2,
    CL_PROG    = 3'd3,
    CL_ERASE   = 3'd4,
    CL_OTP_WR  = 3'd5,
    CL_QUAD_RD = 3'd6,
    CL_RSVD    = 3'd7
  } cmd_class_e;

  localparam logic [1:0] SRP_PIN_GUARD = 2'b01;

  // Top-of-array region: 2^code blocks, saturating to the full array.
  function automatic logic in_prot_range(input logic [3:0] code,
                                         input logic [31:0] blk,
                                         input int aw);
    logic [31:0] top;
    if (code == 4'd0) return 1'b0;
    if (int'(code) >= aw) return 1'b1;
    top = (32'd1 << (aw - int'(code))) - 32'd1;
    return (blk >> code) == top;
  endfunction
endpackage

// File: rtl/wp_pin_sampler.sv
module wp_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wp_n,
  output logic cs_fall,
  output logic pin_eff
);
  logic cs_n_q;
  logic wp_lat;

  assign cs_fall = cs_n_q & ~cs_n;
  assign pin_eff = cs_fall ? wp_n : wp_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      wp_lat <= 1'b1;
    end else begin
      cs_n_q <= cs_n;
      if (cs_fall) wp_lat <= wp_n;
    end
  end
endmodule

// File: rtl/wp_range_chk.sv
module wp_range_chk #(
  parameter int AW = 10
) (
  input  logic [3:0]    bp,
  input  logic [AW-1:0] blk_addr,
  output logic          in_prot
);
  import wp_gate_pkg::*;
  assign in_prot = in_prot_range(bp, 32'(blk_addr), AW);
endmodule

// File: rtl/wp_policy.sv
module wp_policy (
  input  logic [2:0] cmd_class,
  input  logic       hw_mode,
  input  logic       pin_eff,
  input  logic [1:0] srp,
  input  logic       in_prot,
  output logic       deny,
  output logic       is_array,
  output logic       is_quad
);
  import wp_gate_pkg::*;
  cmd_class_e cls;
  logic hw_lock;

  assign cls     = cmd_class_e'(cmd_class);
  assign hw_lock = hw_mode & ~pin_eff;

  always_comb begin
    deny     = 1'b0;
    is_array = 1'b0;
    is_quad  = 1'b0;
    unique case (cls)
      CL_SR1_WR:  deny = hw_mode ? ~pin_eff : (~pin_eff & (srp == SRP_PIN_GUARD));
      CL_REG_WR,
      CL_OTP_WR:  deny = hw_lock;
      CL_PROG,
      CL_ERASE: begin
        deny     = hw_lock | in_prot;
        is_array = 1'b1;
      end
      CL_QUAD_RD: begin
        deny    = hw_mode;
        is_quad = 1'b1;
      end
      default:    deny = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate #(
  parameter int BLK_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_class,
  input  logic [BLK_AW-1:0] blk_addr,
  input  logic              wp_n,
  input  logic              hw_mode,
  input  logic [3:0]        bp,
  input  logic [1:0]        srp,
  output logic              cmd_allow,
  output logic              cmd_reject,
  output logic              array_go,
  output logic              grant,
  output logic              wp_io
);
  logic cs_fall, pin_eff, in_prot, deny, is_array, is_quad, accept;

  assign accept = cmd_valid & ~cs_n;

  wp_pin_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cs_fall(cs_fall), .pin_eff(pin_eff)
  );

  wp_range_chk #(.AW(BLK_AW)) u_rng (
    .bp(bp), .blk_addr(blk_addr), .in_prot(in_prot)
  );

  wp_policy u_pol (
    .cmd_class(cmd_class), .hw_mode(hw_mode), .pin_eff(pin_eff), .srp(srp),
    .in_prot(in_prot), .deny(deny), .is_array(is_array), .is_quad(is_quad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_allow  <= 1'b0;
      cmd_reject <= 1'b0;
      array_go   <= 1'b0;
      grant      <= 1'b0;
      wp_io      <= 1'b0;
    end else begin
      cmd_allow  <= accept & ~deny;
      cmd_reject <= accept & deny;
      array_go   <= accept & ~deny & is_array;
      if (cs_n) begin
        grant <= 1'b0;
        wp_io <= 1'b0;
      end else if (accept) begin
        grant <= ~deny;
        wp_io <= ~deny & is_quad;
      end
    end
  end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hw_mode,
  input logic [2:0] cmd_class,
  input logic       accept,
  input logic       deny,
  input logic       pin_eff,
  input logic       cmd_allow,
  input logic       cmd_reject,
  input logic       array_go,
  input logic       grant,
  input logic       wp_io
);
  // R3
  allow_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_allow && cmd_reject));
  // R3
  pulse_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_allow || cmd_reject) |-> $past(accept));
  // R3
  accept_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_allow || cmd_reject));
  // R4
  hw_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hw_mode && !pin_eff && cmd_class >= 3'd1 && cmd_class <= 3'd5) |=> cmd_reject);
  // R5
  hw_quad_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hw_mode && cmd_class == 3'd6) |=> cmd_reject);
  // R8
  array_go_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_go |-> cmd_allow);
  // R9
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !accept) |=> !grant);
  // R10
  wp_io_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wp_io) |-> ($past(accept) && !$past(deny)));
  // R11
  read_never_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd_class == 3'd0 || cmd_class == 3'd7)) |-> !deny);
endmodule

bind flash_wp_gate wp_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hw_mode(hw_mode),
  .cmd_class(cmd_class), .accept(accept), .deny(deny), .pin_eff(pin_eff),
  .cmd_allow(cmd_allow), .cmd_reject(cmd_reject), .array_go(array_go),
  .grant(grant), .wp_io(wp_io)
);

// File: tb/flash_wp_gate_bench.sv
module flash_wp_gate_bench;
  localparam int AW = 6;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic [AW-1:0] blk_addr = '0;
  logic wp_n = 1'b1;
  logic hw_mode = 1'b0;
  logic [3:0] bp = 4'd0;
  logic [1:0] srp = 2'd0;
  logic cmd_allow, cmd_reject, array_go, grant, wp_io;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wp_gate #(.BLK_AW(AW)) u_flash_wp_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .blk_addr(blk_addr), .wp_n(wp_n),
    .hw_mode(hw_mode), .bp(bp), .srp(srp), .cmd_allow(cmd_allow),
    .cmd_reject(cmd_reject), .array_go(array_go), .grant(grant), .wp_io(wp_io)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit prot(input int code, input int a);
    if (code == 0) return 1'b0;
    if (code >= AW) return 1'b1;
    return a >= NB - (1 << code);
  endfunction

  function automatic bit exp_deny(input int c, input bit hw, input bit pin,
                                  input int sp, input int code, input int a);
    case (c)
      1: return hw ? !pin : (!pin && sp == 1);
      2, 5: return hw && !pin;
      3, 4: return (hw && !pin) || prot(code, a);
      6: return hw;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_cmd(input int c, input int a, input bit pin, input bit hw,
                         input int sp, input int code, input string req);
    bit d;
    d = exp_deny(c, hw, pin, sp, code, a);
    @(negedge clk);
    hw_mode = hw; bp = 4'(code); srp = 2'(sp); wp_n = pin; cs_n = 1'b0;
    @(negedge clk);
    wp_n = ~pin; // R2: late change must be ignored
    cmd_valid = 1'b1; cmd_class = 3'(c); blk_addr = AW'(a);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " R3 allow"}, cmd_allow, !d);
    check({req, " R3 reject"}, cmd_reject, d);
    check({req, " R8 array_go"}, array_go, !d && (c == 3 || c == 4));
    check({req, " R10 wp_io"}, wp_io, !d && c == 6);
    @(negedge clk);
    check({req, " R3 pulse width"}, cmd_allow | cmd_reject, 1'b0);
    check({req, " R9 grant held"}, grant, !d);
    cs_n = 1'b1;
    @(negedge clk);
    check({req, " R9 grant release"}, grant, 1'b0);
    check({req, " R10 wp_io release"}, wp_io, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 allow in reset", cmd_allow, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 allow", cmd_allow, 1'b0);
    check("R1 reject", cmd_reject, 1'b0);
    check("R1 array_go", array_go, 1'b0);
    check("R1 grant", grant, 1'b0);
    check("R1 wp_io", wp_io, 1'b0);

    // Policy sweep: R2 R4 R5 R6 R11
    for (int c = 0; c < 8; c++)
      for (int hw = 0; hw < 2; hw++)
        for (int pin = 0; pin < 2; pin++)
          for (int sp = 0; sp < 4; sp++)
            run_cmd(c, 0, pin[0], hw[0], sp, 0, "policy R4 R5 R6 R11");

    // Range sweep: R7
    for (int code = 0; code < 16; code++)
      for (int a = 0; a < NB; a++)
        run_cmd(((a + code) % 2 == 0) ? 3 : 4, a, 1'b1, 1'b0, 0, code, "range R7");

    // Pin low in hw mode overrides unprotected range: R4
    run_cmd(3, 0, 1'b0, 1'b1, 0, 0, "R4 prog");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule